// File: doc/BRIEF.md
# Slot Presence Monitor

This block watches one removable-module hot-plug slot and reports whether a module is seated in it. A raw presence level from the physical-layer detector is brought into the clock domain through a chain of synchronizer flops. Each transition of the synchronized level updates a presence-state bit and sets a sticky presence-changed flag. Insertion and removal both set the same flag.

Software clears the presence-changed flag by writing a one to it through a write-one-to-clear status port. A slot interrupt request is raised as a level whenever the flag is set and two control enables are both on: a per-event presence-detect enable and a global hot-plug interrupt enable. Only module-style hot-plug is covered. There is no edge-connector mechanical logic, no power sequencing and no attention button.

Top module: `slot_presence_monitor`

## Requirements
- R1: When the raw presence input rises, `pres_state_o` becomes 1 and `pres_chg_o` becomes 1. Both outputs change on the third rising clock edge after the input change.
- R2: When the raw presence input falls, `pres_state_o` becomes 0 and `pres_chg_o` becomes 1, with the same three-edge latency as R1.
- R3: `irq_o` is 1 exactly when `pres_chg_o`, `ctl_pres_en_i` and `ctl_hp_en_i` are all 1. It follows a change of either enable without a clock edge.
- R4: `pres_chg_o` is sticky. It stays 1 until a status write (`sts_wr_i`=1) with `sts_wdata_chg_i`=1, which clears it on the next rising edge.
- R5: A status write with `sts_wdata_chg_i`=0 leaves `pres_chg_o` unchanged.
- R6: If a presence transition and a clearing status write take effect on the same edge, `pres_chg_o` is 1 after that edge.
- R7: The raw presence input passes through a two-flop synchronizer. No output reacts to an input change before the third rising edge after it.
- R8: After reset, `pres_state_o` equals the level of the raw presence input, and `pres_chg_o` and `irq_o` are 0. This holds even when a module is present during reset.
- R9: Further transitions while `pres_chg_o` is 1 keep it at 1, while `pres_state_o` keeps following the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pres_raw_i | input | 1 | Raw presence level from the physical-layer detector |
| ctl_pres_en_i | input | 1 | Presence-detect event enable |
| ctl_hp_en_i | input | 1 | Global hot-plug interrupt enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_chg_i | input | 1 | Write data for the presence-changed bit (1 clears it) |
| pres_state_o | output | 1 | Synchronized presence state |
| pres_chg_o | output | 1 | Sticky presence-changed flag |
| irq_o | output | 1 | Level slot interrupt request |

## Verification
Two functions can land on the same clock edge: setting the flag after a synchronized presence transition, and clearing it through a software write. The bench forces this case. It toggles the raw input and drives a one-cycle clearing write two cycles later, so both reach the status register on the same edge. The scoreboard then expects the flag to read 1 on that edge. A separate case clears the flag with no transition pending, to show that the clear alone works.

// File: rtl/psm_pkg.sv
package psm_pkg;
  // number of synchronizer flops on the raw presence input
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // number of flops in the reset release chain
  localparam int unsigned RST_STAGES_DEF  = 2;

  typedef struct packed {
    logic present;
    logic changed;
  } slot_status_t;
endpackage

// File: rtl/psm_reset_sync.sv
module psm_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/psm_sync.sv
module psm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = d_i;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/psm_presence_track.sv
module psm_presence_track
  import psm_pkg::*;
#(
  parameter int unsigned PRIME_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pres_sync_i,
  input  logic         sts_wr_i,
  input  logic         sts_wdata_chg_i,
  output slot_status_t status_o
);
  localparam int unsigned CNT_W = $clog2(PRIME_CYCLES + 1);

  logic             pres_q, pres_d;
  logic             chg_q, chg_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             edge_det;
  logic             clr_req;

  // next-state logic
  always_comb begin
    edge_det = armed_q & (pres_sync_i != pres_q);
    clr_req  = sts_wr_i & sts_wdata_chg_i;
    pres_d   = pres_sync_i;
    chg_d    = edge_det | (chg_q & ~clr_req);
    cnt_en   = ~armed_q;
    cnt_d    = cnt_q + 1'b1;
    armed_d  = armed_q | (cnt_q == CNT_W'(PRIME_CYCLES - 1));
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= 1'b0;
      chg_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pres_q  <= pres_d;
      chg_q   <= chg_d;
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign status_o.present = pres_q;
  assign status_o.changed = chg_q;

  // R6: a detected transition always leaves the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> chg_q);
  // R4: the flag holds unless a clearing write is present
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !clr_req) |=> chg_q);
  // R5: a write with a zero in the flag lane keeps a set flag
  a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && sts_wr_i && !sts_wdata_chg_i) |=> chg_q);
  // R8: no change is flagged while the synchronizer is still filling
  a_r8_quiet_prime: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !chg_q);
  // R1/R2: a transition flips the presence state on the next edge
  a_r1_state_flip: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> (pres_q != $past(pres_q)));
endmodule

// File: rtl/psm_irq_gate.sv
module psm_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic pres_en_i,
  input  logic hp_en_i,
  output logic irq_o
);
  logic gate_en;

  always_comb begin
    gate_en = pres_en_i & hp_en_i;
    irq_o   = chg_i & gate_en;
  end

  // R3: never request without a pending change
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_i |-> !irq_o);
  // R3: a disabled global enable masks the request
  a_r3_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_en_i |-> !irq_o);
endmodule

// File: rtl/slot_presence_monitor.sv
module slot_presence_monitor
  import psm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned RST_STAGES  = RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_raw_i,
  input  logic ctl_pres_en_i,
  input  logic ctl_hp_en_i,
  input  logic sts_wr_i,
  input  logic sts_wdata_chg_i,
  output logic pres_state_o,
  output logic pres_chg_o,
  output logic irq_o
);
  localparam int unsigned PRIME_CYCLES = SYNC_STAGES + 1;

  logic         rst_core_n;
  logic         pres_sync;
  slot_status_t status;

  psm_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  psm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (pres_raw_i),
    .q_o   (pres_sync)
  );

  psm_presence_track #(.PRIME_CYCLES(PRIME_CYCLES)) u_track (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .pres_sync_i     (pres_sync),
    .sts_wr_i        (sts_wr_i),
    .sts_wdata_chg_i (sts_wdata_chg_i),
    .status_o        (status)
  );

  psm_irq_gate u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .chg_i     (status.changed),
    .pres_en_i (ctl_pres_en_i),
    .hp_en_i   (ctl_hp_en_i),
    .irq_o     (irq_o)
  );

  assign pres_state_o = status.present;
  assign pres_chg_o   = status.changed;

  // R9: while the flag is set and no clear arrives, it stays set
  a_r9_hold_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pres_chg_o && !(sts_wr_i && sts_wdata_chg_i)) |=> pres_chg_o);
endmodule

// File: tb/slot_presence_monitor_tb_top.sv
module slot_presence_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic pres_raw, pres_en, hp_en, wr, wdata;
  logic pres_state, pres_chg, irq;

  typedef struct {
    int    cyc;
    bit    pres;
    bit    chg;
    bit    irq;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  slot_presence_monitor dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .pres_raw_i      (pres_raw),
    .ctl_pres_en_i   (pres_en),
    .ctl_hp_en_i     (hp_en),
    .sts_wr_i        (wr),
    .sts_wdata_chg_i (wdata),
    .pres_state_o    (pres_state),
    .pres_chg_o      (pres_chg),
    .irq_o           (irq)
  );

  // push an expected output set for the cycle 'dly' edges from now
  task automatic expect_at(input int dly, input bit p, input bit c, input bit i,
                           input string tag);
    exp_t e;
    e.cyc = cyc + dly; e.pres = p; e.chg = c; e.irq = i; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor: compare scoreboard items when their cycle is reached
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (e.cyc != cyc || pres_state !== e.pres || pres_chg !== e.chg || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: cyc=%0d got pres=%b chg=%b irq=%b expected pres=%b chg=%b irq=%b (due %0d)",
                 e.tag, cyc, pres_state, pres_chg, irq, e.pres, e.chg, e.irq, e.cyc);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pres_raw = 1'b1; pres_en = 1'b0; hp_en = 1'b0; wr = 1'b0; wdata = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(10);
    // R8: module present across reset: state follows input, no change flagged
    expect_at(1, 1, 0, 0, "R8 reset state");
    step(2);
    pres_en = 1'b1; hp_en = 1'b1;
    expect_at(1, 1, 0, 0, "R3 no irq without change");
    step(2);

    // R2/R7: removal
    pres_raw = 1'b0;
    expect_at(1, 1, 0, 0, "R7 no reaction edge 1");
    expect_at(2, 1, 0, 0, "R7 no reaction edge 2");
    expect_at(3, 0, 1, 1, "R2 removal edge 3");
    step(5);

    // R5: write with zero in the flag lane
    wr = 1'b1; wdata = 1'b0;
    expect_at(1, 0, 1, 1, "R5 zero write ignored");
    step(1); wr = 1'b0;
    expect_at(2, 0, 1, 1, "R4 sticky hold");
    step(3);

    // R3: enable gating
    pres_en = 1'b0;
    expect_at(1, 0, 1, 0, "R3 event enable off");
    step(1);
    pres_en = 1'b1; hp_en = 1'b0;
    expect_at(1, 0, 1, 0, "R3 global enable off");
    step(1);
    hp_en = 1'b1;
    expect_at(1, 0, 1, 1, "R3 both enables on");
    step(1);

    // R4: clear with a one
    wr = 1'b1; wdata = 1'b1;
    expect_at(1, 0, 0, 0, "R4 clear");
    step(1); wr = 1'b0;
    expect_at(3, 0, 0, 0, "R4 stays clear");
    step(4);

    // R1: insertion
    pres_raw = 1'b1;
    expect_at(2, 0, 0, 0, "R7 insertion not early");
    expect_at(3, 1, 1, 1, "R1 insertion");
    step(5);

    // R9: short removal pulse while flag already set
    pres_raw = 1'b0;
    expect_at(3, 0, 1, 1, "R9 removal keeps flag");
    step(1);
    pres_raw = 1'b1;
    expect_at(3, 1, 1, 1, "R9 reinsertion keeps flag");
    step(5);

    // clear, then R6: transition and clear on the same edge
    wr = 1'b1; wdata = 1'b1;
    expect_at(1, 1, 0, 0, "R4 clear before collision");
    step(1); wr = 1'b0;
    step(2);
    pres_raw = 1'b0;
    step(2);
    wr = 1'b1; wdata = 1'b1;
    expect_at(1, 0, 1, 1, "R6 set wins over clear");
    step(1); wr = 1'b0;
    expect_at(2, 0, 1, 1, "R6 flag stays after collision");
    step(4);

    // mid-run reset with module absent
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(10);
    expect_at(1, 0, 0, 0, "R8 reset with module absent");
    step(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule